// File: doc/BRIEF.md
# Programmable Integer Clock Divider with Relock Status

The block divides a reference clock by an integer ratio set through a small register bus. One control word gives separate high-phase and low-phase counts in reference cycles; their sum is the divide ratio. An edge-select bit stretches the high phase by half a reference period, so odd ratios come out with a near-50% duty cycle. A bypass bit makes the output follow the reference directly, which is how a ratio of one is selected.

Writing the control word starts a relock sequence. The lock status bit drops, stays low for a fixed number of reference cycles, and then returns. At that moment the new word reaches the running divider, whose phase counter restarts at the start of a high phase. A write with the hold bit set only parks the word in a shadow register. The running divider and the lock bit are left alone until a later write with the hold bit clear.

Control state machine: `CT_LOCKED` goes to `CT_RELOCK` on a committing write. `CT_RELOCK` stays in `CT_RELOCK` (restarting its wait) on another committing write. It returns to `CT_LOCKED` when the wait count reaches its end, which applies the word. Phase state machine: `PH_HIGH` goes to `PH_LOW` after the effective high count. `PH_LOW` goes to `PH_HIGH` after the effective low count. Either state is forced to `PH_HIGH` when a new word is applied.

Top module: `clkdiv_relock`

## Requirements
- R1: After reset the word register reads 0x0000_2000 (bypass set, all counts zero), the lock bit reads 1 and the output follows the reference clock.
- R2: Address 0 reads back the last written word in bits 14:0: low count 5:0, high count 11:6, edge select 12, bypass 13, hold 14. Bits 31:15 read 0 whatever was written there.
- R3: With edge select 0 and bypass 0, the output period is (high+low) reference cycles and the output is high for exactly the high count.
- R4: With edge select 1, the output period is still (high+low) cycles, but the high phase lasts high+0.5 cycles, so an odd ratio N written as low=(N>>1)+1, high=N>>1 gives a half-duty output.
- R5: With bypass 1, the output equals the reference clock whatever the counts are.
- R6: A write to address 0 with the hold bit clear drops the lock bit from the next cycle. The bit stays 0 for exactly LOCK_CYCLES reference cycles and then returns to 1 with the new word in effect. The running setting does not change while lock is 0.
- R7: A write with the hold bit set updates only the shadow word. The lock bit stays 1 and the output keeps its previous period until a later write with the hold bit clear.
- R8: A high or low count of 0 acts as 1.
- R9: A committing write during a relock restarts the full LOCK_CYCLES wait, and the latest word is the one applied.
- R10: Address 1 reads the lock bit in bit 0, and bits 31:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising reference edge |
| bus_addr | input | 1 | 0 = control word, 1 = lock status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| clk_out | output | 1 | Divided clock |

## Verification
A wrong control state appears at the status port within one cycle of a write: the lock bit fails to drop, or it returns too early or too late. A wrong wait count shows as a low-lock window whose length differs from LOCK_CYCLES. A wrong phase state or count shows at clk_out within one output period, as a changed period or high time. A missed negative-edge stage removes the half-cycle from the high time in edge mode. Shadow and active words are separated by checking that hold writes read back while the measured period stays the same.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    parameter int CDIV_CNT_W = 6;

    typedef struct packed {
        logic                  hold;
        logic                  bypass;
        logic                  edge_sel;
        logic [CDIV_CNT_W-1:0] hi_cnt;
        logic [CDIV_CNT_W-1:0] lo_cnt;
    } cdiv_word_t;

    localparam int CDIV_WORD_W = $bits(cdiv_word_t);

    localparam cdiv_word_t CDIV_RESET_WORD = '{
        hold: 1'b0, bypass: 1'b1, edge_sel: 1'b0,
        hi_cnt: '0, lo_cnt: '0
    };

    typedef enum logic { CT_LOCKED, CT_RELOCK } ctl_state_t;
    typedef enum logic { PH_HIGH, PH_LOW } ph_state_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
    import clkdiv_pkg::*;
#(
    parameter int LOCK_CYCLES = 16
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       wr_word,
    input  cdiv_word_t wr_data,
    output cdiv_word_t shadow_q,
    output cdiv_word_t active_q,
    output logic       locked,
    output logic       restart
);
    localparam int WAIT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(LOCK_CYCLES - 1);

    ctl_state_t        state_q, state_d;
    logic [WAIT_W-1:0] wait_q, wait_d;
    logic              commit;

    assign commit = wr_word && !wr_data.hold;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CT_LOCKED;
            wait_q   <= '0;
            shadow_q <= CDIV_RESET_WORD;
            active_q <= CDIV_RESET_WORD;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
            if (wr_word)
                shadow_q <= wr_data;
            if (restart)
                active_q <= shadow_q;
        end
    end

    always_comb begin
        state_d = state_q;
        wait_d  = wait_q;
        restart = 1'b0;
        unique case (state_q)
            CT_LOCKED: begin
                if (commit) begin
                    state_d = CT_RELOCK;
                    wait_d  = '0;
                end
            end
            CT_RELOCK: begin
                if (commit) begin
                    wait_d = '0;
                end else if (wait_q == WAIT_LAST) begin
                    state_d = CT_LOCKED;
                    restart = 1'b1;
                end else begin
                    wait_d = wait_q + 1'b1;
                end
            end
        endcase
    end

    assign locked = (state_q == CT_LOCKED);

    AST_COMMIT_DROPS_LOCK: assert property (@(posedge clk_ref) disable iff (!rst_n)
        commit |=> !locked); // R6
    AST_HOLD_KEEPS_SETTING: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (wr_word && wr_data.hold && locked) |=> (locked && $stable(active_q))); // R7
    AST_SETTING_FROZEN_UNLOCKED: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!locked && $past(!locked)) |-> $stable(active_q)); // R6
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
    import clkdiv_pkg::*;
(
    input  logic                  clk_ref,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic [CDIV_CNT_W-1:0] hi_cnt,
    input  logic [CDIV_CNT_W-1:0] lo_cnt,
    output logic                  q_pos
);
    ph_state_t             state_q, state_d;
    logic [CDIV_CNT_W-1:0] cnt_q, cnt_d;
    logic [CDIV_CNT_W-1:0] hi_eff, lo_eff;

    assign hi_eff = (hi_cnt == '0) ? CDIV_CNT_W'(1) : hi_cnt;
    assign lo_eff = (lo_cnt == '0) ? CDIV_CNT_W'(1) : lo_cnt;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_HIGH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        if (restart) begin
            state_d = PH_HIGH;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PH_HIGH: if (cnt_q == hi_eff - 1'b1) begin
                    state_d = PH_LOW;
                    cnt_d   = '0;
                end
                PH_LOW: if (cnt_q == lo_eff - 1'b1) begin
                    state_d = PH_HIGH;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign q_pos = (state_q == PH_HIGH);

    AST_HIGH_WITHIN_COUNT: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == PH_HIGH) |-> (cnt_q < hi_eff)); // R8
    AST_LOW_WITHIN_COUNT: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == PH_LOW) |-> (cnt_q < lo_eff)); // R8
endmodule

// File: rtl/clkdiv_outstage.sv
module clkdiv_outstage (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic q_pos,
    input  logic edge_sel,
    input  logic bypass,
    output logic clk_out
);
    logic q_neg;

    always_ff @(negedge clk_ref or negedge rst_n) begin
        if (!rst_n) q_neg <= 1'b0;
        else        q_neg <= q_pos;
    end

    always_comb begin
        if (bypass)        clk_out = clk_ref;
        else if (edge_sel) clk_out = q_pos | q_neg;
        else               clk_out = q_pos;
    end
endmodule

// File: rtl/clkdiv_relock.sv
module clkdiv_relock
    import clkdiv_pkg::*;
#(
    parameter int LOCK_CYCLES = 16
) (
    input  logic        clk_ref,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        clk_out
);
    cdiv_word_t shadow_w, active_w;
    logic       locked, restart, q_pos;

    clkdiv_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .wr_word (bus_wr && !bus_addr),
        .wr_data (cdiv_word_t'(bus_wdata[CDIV_WORD_W-1:0])),
        .shadow_q(shadow_w),
        .active_q(active_w),
        .locked  (locked),
        .restart (restart)
    );

    clkdiv_phase u_phase (
        .clk_ref(clk_ref),
        .rst_n  (rst_n),
        .restart(restart),
        .hi_cnt (active_w.hi_cnt),
        .lo_cnt (active_w.lo_cnt),
        .q_pos  (q_pos)
    );

    clkdiv_outstage u_out (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .q_pos   (q_pos),
        .edge_sel(active_w.edge_sel),
        .bypass  (active_w.bypass),
        .clk_out (clk_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr) bus_rdata[0] = locked;
        else          bus_rdata[CDIV_WORD_W-1:0] = shadow_w;
    end

    AST_APPLY_RAISES_LOCK: assert property (@(posedge clk_ref) disable iff (!rst_n)
        restart |=> (locked && active_w == $past(shadow_w))); // R6
endmodule

// File: tb/clkdiv_relock_test.sv
`timescale 1ns/1ps
module clkdiv_relock_test;
    localparam int LC = 16;

    logic        clk_ref = 1'b0;
    logic        rst_n   = 1'b0;
    logic        bus_wr  = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string   req;
        realtime per;
        realtime hi;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk_ref = ~clk_ref;

    clkdiv_relock #(.LOCK_CYCLES(LC)) uut (
        .clk_ref(clk_ref), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_out(clk_out)
    );

    task automatic check_val(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_time(string req, string what, realtime act, realtime exp);
        checks++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            errors++;
            $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic a, logic [31:0] d);
        @(negedge clk_ref);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk_ref);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // driver: push expected clock shape
    task automatic expect_clock(string req, realtime per, realtime hi);
        exp_t e;
        e.req = req; e.per = per; e.hi = hi;
        sb_q.push_back(e);
    endtask

    // monitor: pop one expectation and compare against measured output
    task automatic monitor_clock();
        exp_t e;
        realtime t0, t1, t2;
        e = sb_q.pop_front();
        repeat (2) @(posedge clk_out);
        t0 = $realtime;
        @(negedge clk_out);
        t1 = $realtime;
        @(posedge clk_out);
        t2 = $realtime;
        check_time(e.req, "period", t2 - t0, e.per);
        check_time(e.req, "high", t1 - t0, e.hi);
    endtask

    // count lock-low cycles right after a committing write
    task automatic lock_window(string req);
        logic [31:0] d;
        int n = 0;
        bus_read(1'b1, d);
        check_val(req, {31'd0, d[0]}, 32'd0);
        while (d[0] == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk_ref);
            bus_read(1'b1, d);
        end
        check_val(req, n, LC);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk_ref);
        rst_n = 1'b1;
        @(negedge clk_ref);

        // R1 reset state
        bus_read(1'b0, d); check_val("R1 word", d, 32'h0000_2000);
        bus_read(1'b1, d); check_val("R1 R10 status", d, 32'h1);
        expect_clock("R1 R5 reset bypass", 10.0, 5.0); monitor_clock();

        // R3 even ratio 4: H=2 L=2
        bus_write(1'b0, 32'h0000_0082); lock_window("R6 first relock");
        expect_clock("R3 ratio4", 40.0, 20.0); monitor_clock();

        // R4 odd ratio 3: L=2 H=1 edge
        bus_write(1'b0, 32'h0000_1042); lock_window("R6");
        expect_clock("R4 ratio3", 30.0, 15.0); monitor_clock();

        // R4 odd ratio 5: L=3 H=2 edge
        bus_write(1'b0, 32'h0000_1083); lock_window("R6");
        expect_clock("R4 ratio5", 50.0, 25.0); monitor_clock();

        // R7 hold write, reserved bits set (R2)
        bus_write(1'b0, 32'hFFFF_C0C3);
        bus_read(1'b1, d); check_val("R7 lock stays", d, 32'h1);
        bus_read(1'b0, d); check_val("R2 R7 readback", d, 32'h0000_40C3);
        expect_clock("R7 unchanged", 50.0, 25.0); monitor_clock();
        bus_write(1'b0, 32'h0000_00C3); lock_window("R7 commit");
        expect_clock("R7 R3 ratio6", 60.0, 30.0); monitor_clock();

        // R8 zero counts
        bus_write(1'b0, 32'h0000_0000); lock_window("R8");
        expect_clock("R8 both zero", 20.0, 10.0); monitor_clock();
        bus_write(1'b0, 32'h0000_0003); lock_window("R8");
        expect_clock("R8 high zero", 40.0, 10.0); monitor_clock();

        // R9 write during relock
        bus_write(1'b0, 32'h0000_0082);
        repeat (5) @(negedge clk_ref);
        bus_write(1'b0, 32'h0000_00C4); lock_window("R9 restart");
        bus_read(1'b0, d); check_val("R9 word", d, 32'h0000_00C4);
        expect_clock("R9 latest", 70.0, 30.0); monitor_clock();

        // R5 bypass with nonzero counts
        bus_write(1'b0, 32'h0000_2082); lock_window("R5");
        expect_clock("R5 bypass", 10.0, 5.0); monitor_clock();
        bus_read(1'b1, d); check_val("R10 status", d, 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule